// File: doc/BRIEF.md
# Parallel flash buffered-program sequencer

This block sits on the host side of a 16-bit parallel NOR flash and writes a short run of bytes with the device's buffered-program command set. A request gives a starting byte address and a byte count. The bytes then arrive on a valid/ready stream. The sequencer packs them into bus words and drives the flash bus through the full command exchange. That exchange is a status check, clearing of stale error flags, the buffer setup command, the word count, the data words and the confirm command. It then polls for completion under a programmable timeout.

Each request ends with a single-cycle completion pulse carrying a 3-bit result code. The code reports success, a device that never offered its buffer, a program that never finished, or one of three program errors decoded from the final status in a fixed priority. A request whose bytes would not fit inside one program buffer is refused at once, with no bus cycle at all. The buffer size comes from an interleave factor and a size exponent given as parameters. The polling interval and the setup opcode variant are also parameters.

Top module: `flash_bufprog`

## Requirements
- R1: Every command and status access of a request goes to the command word address. This is the start byte address with its low log2(buffer bytes) bits cleared, shifted right by one. The buffer size is INTERLEAVE << BUF_EXP, which is 32 bytes by default.
- R2: After reset, the first accepted request writes 0x70 to the command address before its first status read. Every later request skips that write, because any finished request leaves the device in status mode.
- R3: The sequencer reads status and checks bits 4 and 5 (mask 0x30). If either is set, it writes 0x50 and then 0x70 before the setup command. If both are clear, it goes straight to setup.
- R4: The buffer setup command is 0xE8. When the PERF_VARIANT parameter is set, it is 0xE9.
- R5: After setup, status bit 7 is polled for buffer readiness. If the timeout passes without it, the sequencer writes 0x70, performs one status read, writes 0x50, writes 0x70, and ends with code 1.
- R6: Once the buffer is ready, the next write to the command address is the number of data words minus one. The number of data words is ceil((start_addr mod 2 + length) / 2).
- R7: Data words go to consecutive word addresses starting at start_addr >> 1. The byte at an even address sits in bits 7:0 and the byte at an odd address in bits 15:8. A lane before the first byte or after the last byte is 0xFF. The stream is consumed in order, and a byte is taken only on a cycle where byte_valid_i and byte_ready_o are both high.
- R8: After the last data word, 0xD0 is written to the command address and bit 7 is polled. Ready status with none of bits 1, 3 and 4 set (mask 0x1A) ends the request with code 0.
- R9: If the timeout passes after confirm without ready, the sequencer writes 0x70 and ends with code 2.
- R10: If the final status has any of mask 0x1A, the sequencer writes 0x50 and then 0x70. The code is 3 when bit 1 is set, otherwise 4 when bit 3 is set, otherwise 5.
- R11: A length of zero, or a start offset within the buffer plus the length greater than the buffer size, ends the request with code 6 on the next cycle with no read or write strobe.
- R12: The write and read strobes are never high together. A status value is sampled from fl_dq_i one cycle after its read strobe. While waiting, one read strobe is issued every POLL_DIV cycles, starting the cycle after the command write.
- R13: done_o is high for exactly one cycle per request. busy_o is high from acceptance until completion. start_i is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when idle |
| addr_i | input | ADDR_W | Start byte address |
| len_i | input | LEN_W | Byte count |
| timeout_i | input | 32 | Wait limit in clock cycles for each polling phase |
| byte_valid_i | input | 1 | Stream byte present |
| byte_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Stream byte accepted this cycle when valid |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| code_o | output | 3 | Result code, valid with done_o |
| fl_addr_o | output | ADDR_W-1 | Flash word address |
| fl_dq_o | output | DQ_W | Flash write data |
| fl_dq_i | input | DQ_W | Flash read data |
| fl_we_o | output | 1 | Flash write strobe, one cycle per write |
| fl_re_o | output | 1 | Flash read strobe, one cycle per read |

## Verification
On every cycle, the embedded properties check that the strobes never overlap and that read strobes keep their spacing while polling. They check that a status with bits 4 or 5 set is answered by the clear command, and that each clear command is followed by the status-mode command. They also check that data word addresses step by one, that bytes are never taken past the count, and that an oversized request completes silently with the reject code. A success code never accompanies error bits in the captured status. The bench scenarios use a behavioural flash that records every bus write. Only these scenarios can show the complete command order, the 0xFF padding for odd starts and short tails, and the word count. They also cover the status-mode skip on later requests, the decode priority among the error bits, both timeout paths, and a start request ignored while busy.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_SRCMD, S_SRRD, S_SRCHK, S_CLR50, S_CLR70, S_SETUP, S_XWAIT,
    S_NR70, S_NRRD, S_NRCHK, S_NR50, S_NR70B, S_COUNT, S_DATA, S_WORD,
    S_CONF, S_PWAIT, S_TO70, S_E50, S_E70
  } fbp_state_e;

  localparam logic [2:0] RC_OK       = 3'd0;
  localparam logic [2:0] RC_NOTREADY = 3'd1;
  localparam logic [2:0] RC_TIMEOUT  = 3'd2;
  localparam logic [2:0] RC_LOCKED   = 3'd3;
  localparam logic [2:0] RC_VOLTAGE  = 3'd4;
  localparam logic [2:0] RC_PGMFAIL  = 3'd5;
  localparam logic [2:0] RC_BADLEN   = 3'd6;

  localparam logic [7:0] OP_RDSR      = 8'h70;
  localparam logic [7:0] OP_CLRSR     = 8'h50;
  localparam logic [7:0] OP_SETUP     = 8'hE8;
  localparam logic [7:0] OP_SETUP_ALT = 8'hE9;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;

  localparam logic [7:0] M_STALE = 8'h30;
  localparam logic [7:0] M_ERR   = 8'h1A;

  function automatic logic [2:0] fbp_decode(input logic [7:0] sr);
    if (sr[1])      return RC_LOCKED;
    else if (sr[3]) return RC_VOLTAGE;
    else            return RC_PGMFAIL;
  endfunction

endpackage

// File: rtl/fbp_packer.sv
module fbp_packer #(
  parameter int DQ_W  = 16,
  parameter int WA_W  = 23,
  parameter int LEN_W = 6,
  localparam int LANES = DQ_W / 8,
  localparam int LB    = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LB-1:0]    lane_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [WA_W-1:0]  wadr_i,
  input  logic             take_i,
  input  logic [7:0]       byte_i,
  input  logic             adv_i,
  output logic [DQ_W-1:0]  word_o,
  output logic [WA_W-1:0]  wadr_o,
  output logic             last_o,
  output logic             empty_o
);

  logic [7:0]       lane_b [LANES];
  logic [LB-1:0]    lane_q;
  logic [LEN_W-1:0] rem_q;
  logic [WA_W-1:0]  wadr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      rem_q  <= '0;
      wadr_q <= '0;
      for (int l = 0; l < LANES; l++) lane_b[l] <= 8'hFF;
    end else if (load_i) begin
      lane_q <= lane_i;
      rem_q  <= len_i;
      wadr_q <= wadr_i;
      for (int l = 0; l < LANES; l++) lane_b[l] <= 8'hFF;
    end else if (adv_i) begin
      lane_q <= '0;
      wadr_q <= wadr_q + 1'b1;
      for (int l = 0; l < LANES; l++) lane_b[l] <= 8'hFF;
    end else if (take_i) begin
      for (int l = 0; l < LANES; l++)
        if (lane_q == LB'(l)) lane_b[l] <= byte_i;
      lane_q <= lane_q + 1'b1;
      rem_q  <= rem_q - 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_o[g*8 +: 8] = lane_b[g];
  end

  assign wadr_o  = wadr_q;
  assign last_o  = (lane_q == LB'(LANES - 1)) || (rem_q == LEN_W'(1));
  assign empty_o = (rem_q == '0);

  p_take_nonempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> !empty_o);

  p_wadr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> wadr_o == $past(wadr_o) + 1'b1);

endmodule

// File: rtl/fbp_poller.sv
module fbp_poller #(
  parameter int POLL_DIV = 4,
  localparam int DIV_W = (POLL_DIV > 1) ? $clog2(POLL_DIV) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        run_i,
  input  logic [31:0] limit_i,
  output logic        rd_o,
  output logic        smp_o,
  output logic        expired_o
);

  logic [DIV_W-1:0] div_q;
  logic [31:0]      cyc_q;
  logic             smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cyc_q <= '0;
      smp_q <= 1'b0;
    end else if (clr_i) begin
      div_q <= '0;
      cyc_q <= '0;
      smp_q <= 1'b0;
    end else if (run_i) begin
      div_q <= (div_q == DIV_W'(POLL_DIV - 1)) ? '0 : div_q + 1'b1;
      if (cyc_q != '1) cyc_q <= cyc_q + 1'b1;
      smp_q <= rd_o;
    end else begin
      smp_q <= 1'b0;
    end
  end

  assign rd_o      = run_i && (div_q == '0);
  assign smp_o     = smp_q;
  assign expired_o = (cyc_q >= limit_i);

  if (POLL_DIV > 1) begin : g_gap
    p_poll_gap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_o && !clr_i |=> !rd_o);
  end

endmodule

// File: rtl/flash_bufprog.sv
module flash_bufprog
  import fbp_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int DQ_W         = 16,
  parameter int INTERLEAVE   = 1,
  parameter int BUF_EXP      = 5,
  parameter int POLL_DIV     = 4,
  parameter bit PERF_VARIANT = 1'b0,
  localparam int LANES     = DQ_W / 8,
  localparam int LB        = $clog2(LANES),
  localparam int BUF_BYTES = INTERLEAVE << BUF_EXP,
  localparam int BB_LOG    = $clog2(BUF_BYTES),
  localparam int LEN_W     = BB_LOG + 1,
  localparam int WA_W      = ADDR_W - LB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [31:0]       timeout_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              byte_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        code_o,
  output logic [WA_W-1:0]   fl_addr_o,
  output logic [DQ_W-1:0]   fl_dq_o,
  input  logic [DQ_W-1:0]   fl_dq_i,
  output logic              fl_we_o,
  output logic              fl_re_o
);

  localparam logic [7:0] SETUP_OP = PERF_VARIANT ? OP_SETUP_ALT : OP_SETUP;

  fbp_state_e state_q, nxt;
  logic [WA_W-1:0] cmd_q;
  logic [LEN_W:0]  cnt_q;
  logic [7:0]      stat_q;
  logic            smode_q, done_q;
  logic [2:0]      code_q;

  logic [7:0] sr;
  logic       unused_dq;
  assign sr        = fl_dq_i[7:0];
  assign unused_dq = ^fl_dq_i[DQ_W-1:8];

  // request decode
  logic [LEN_W:0]  span, tot, wm1;
  logic            bad_len;
  logic [WA_W-1:0] cmd_w;
  assign span    = (LEN_W+1)'(addr_i[BB_LOG-1:0]) + (LEN_W+1)'(len_i);
  assign bad_len = (len_i == '0) || (span > (LEN_W+1)'(BUF_BYTES));
  assign tot     = (LEN_W+1)'(addr_i[LB-1:0]) + (LEN_W+1)'(len_i) + (LEN_W+1)'(LANES - 1);
  assign wm1     = (tot >> LB) - 1'b1;
  assign cmd_w   = {addr_i[ADDR_W-1:BB_LOG], {(BB_LOG-LB){1'b0}}};

  logic            p_load, p_take, p_adv, p_last, p_empty;
  logic [DQ_W-1:0] p_word;
  logic [WA_W-1:0] p_wadr;

  fbp_packer #(.DQ_W(DQ_W), .WA_W(WA_W), .LEN_W(LEN_W)) u_pack (
    .clk_i, .rst_ni,
    .load_i (p_load),
    .lane_i (addr_i[LB-1:0]),
    .len_i  (len_i),
    .wadr_i (addr_i[ADDR_W-1:LB]),
    .take_i (p_take),
    .byte_i (byte_i),
    .adv_i  (p_adv),
    .word_o (p_word),
    .wadr_o (p_wadr),
    .last_o (p_last),
    .empty_o(p_empty)
  );

  logic t_clr, t_run, t_rd, t_smp, t_exp;

  fbp_poller #(.POLL_DIV(POLL_DIV)) u_poll (
    .clk_i, .rst_ni,
    .clr_i    (t_clr),
    .run_i    (t_run),
    .limit_i  (timeout_i),
    .rd_o     (t_rd),
    .smp_o    (t_smp),
    .expired_o(t_exp)
  );

  logic       fin, cap;
  logic [2:0] fcode;

  always_comb begin
    nxt          = state_q;
    fl_we_o      = 1'b0;
    fl_re_o      = 1'b0;
    fl_addr_o    = cmd_q;
    fl_dq_o      = '0;
    byte_ready_o = 1'b0;
    p_load       = 1'b0;
    p_take       = 1'b0;
    p_adv        = 1'b0;
    t_clr        = 1'b0;
    t_run        = 1'b0;
    fin          = 1'b0;
    fcode        = RC_OK;
    cap          = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        if (bad_len) begin
          fin   = 1'b1;
          fcode = RC_BADLEN;
        end else begin
          p_load = 1'b1;
          nxt    = smode_q ? S_SRRD : S_SRCMD;
        end
      end
      S_SRCMD: begin fl_we_o = 1'b1; fl_dq_o = DQ_W'(OP_RDSR); nxt = S_SRRD; end
      S_SRRD:  begin fl_re_o = 1'b1; nxt = S_SRCHK; end
      S_SRCHK: nxt = ((sr & M_STALE) != '0) ? S_CLR50 : S_SETUP;
      S_CLR50: begin fl_we_o = 1'b1; fl_dq_o = DQ_W'(OP_CLRSR); nxt = S_CLR70; end
      S_CLR70: begin fl_we_o = 1'b1; fl_dq_o = DQ_W'(OP_RDSR); nxt = S_SETUP; end
      S_SETUP: begin
        fl_we_o = 1'b1; fl_dq_o = DQ_W'(SETUP_OP); t_clr = 1'b1; nxt = S_XWAIT;
      end
      S_XWAIT: begin
        t_run   = 1'b1;
        fl_re_o = t_rd;
        if (t_smp && sr[7]) nxt = S_COUNT;
        else if (t_exp)     nxt = S_NR70;
      end
      S_NR70:  begin fl_we_o = 1'b1; fl_dq_o = DQ_W'(OP_RDSR); nxt = S_NRRD; end
      S_NRRD:  begin fl_re_o = 1'b1; nxt = S_NRCHK; end
      S_NRCHK: nxt = S_NR50;
      S_NR50:  begin fl_we_o = 1'b1; fl_dq_o = DQ_W'(OP_CLRSR); nxt = S_NR70B; end
      S_NR70B: begin
        fl_we_o = 1'b1; fl_dq_o = DQ_W'(OP_RDSR);
        fin = 1'b1; fcode = RC_NOTREADY; nxt = S_IDLE;
      end
      S_COUNT: begin fl_we_o = 1'b1; fl_dq_o = DQ_W'(cnt_q); nxt = S_DATA; end
      S_DATA: begin
        byte_ready_o = 1'b1;
        if (byte_valid_i) begin
          p_take = 1'b1;
          if (p_last) nxt = S_WORD;
        end
      end
      S_WORD: begin
        fl_we_o   = 1'b1;
        fl_addr_o = p_wadr;
        fl_dq_o   = p_word;
        p_adv     = 1'b1;
        nxt       = p_empty ? S_CONF : S_DATA;
      end
      S_CONF: begin
        fl_we_o = 1'b1; fl_dq_o = DQ_W'(OP_CONFIRM); t_clr = 1'b1; nxt = S_PWAIT;
      end
      S_PWAIT: begin
        t_run   = 1'b1;
        fl_re_o = t_rd;
        if (t_smp && sr[7]) begin
          cap = 1'b1;
          if ((sr & M_ERR) != '0) nxt = S_E50;
          else begin fin = 1'b1; fcode = RC_OK; nxt = S_IDLE; end
        end else if (t_exp) nxt = S_TO70;
      end
      S_TO70: begin
        fl_we_o = 1'b1; fl_dq_o = DQ_W'(OP_RDSR);
        fin = 1'b1; fcode = RC_TIMEOUT; nxt = S_IDLE;
      end
      S_E50: begin fl_we_o = 1'b1; fl_dq_o = DQ_W'(OP_CLRSR); nxt = S_E70; end
      S_E70: begin
        fl_we_o = 1'b1; fl_dq_o = DQ_W'(OP_RDSR);
        fin = 1'b1; fcode = fbp_decode(stat_q); nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cmd_q   <= '0;
      cnt_q   <= '0;
      stat_q  <= '0;
      smode_q <= 1'b0;
      done_q  <= 1'b0;
      code_q  <= RC_OK;
    end else begin
      state_q <= nxt;
      done_q  <= fin;
      if (fin) code_q <= fcode;
      if (fin && state_q != S_IDLE) smode_q <= 1'b1;
      if (p_load) begin
        cmd_q <= cmd_w;
        cnt_q <= wm1;
      end
      if (cap) stat_q <= sr;
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign code_o = code_q;

  p_strobe_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_o && fl_re_o));

  p_reject_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_IDLE && start_i && bad_len
    |=> done_o && code_o == RC_BADLEN && !fl_we_o && !fl_re_o);

  p_stale_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_SRCHK && (sr & M_STALE) != '0
    |=> fl_we_o && fl_dq_o == DQ_W'(OP_CLRSR));

  p_clr_then_sr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_we_o && fl_dq_o == DQ_W'(OP_CLRSR) && state_q != S_WORD && state_q != S_COUNT
    |=> fl_we_o && fl_dq_o == DQ_W'(OP_RDSR));

  p_ok_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && code_o == RC_OK |-> (stat_q & M_ERR) == '0);

  p_timeout_sr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_PWAIT && t_exp && !(t_smp && sr[7])
    |=> fl_we_o && fl_dq_o == DQ_W'(OP_RDSR));

endmodule

// File: tb/sim_flash_bufprog.sv
`timescale 1ns/1ps
module sim_flash_bufprog;

  typedef struct packed {
    logic [23:0] a;
    logic [5:0]  len;
    logic [7:0]  pre;
    logic [7:0]  fin;
    logic        sok;
    logic        cok;
    logic        gap;
    logic [2:0]  code;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{24'h000100, 6'd4,  8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 3'd0},
    '{24'h000123, 6'd5,  8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 3'd0},
    '{24'h000300, 6'd32, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 3'd0},
    '{24'h000045, 6'd1,  8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 3'd0},
    '{24'h00051E, 6'd2,  8'h10, 8'h00, 1'b1, 1'b1, 1'b1, 3'd0},
    '{24'h000600, 6'd3,  8'h20, 8'h00, 1'b1, 1'b1, 1'b0, 3'd0},
    '{24'h000700, 6'd4,  8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd1},
    '{24'h000800, 6'd4,  8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 3'd2},
    '{24'h000900, 6'd6,  8'h00, 8'h0A, 1'b1, 1'b1, 1'b0, 3'd3},
    '{24'h000A01, 6'd3,  8'h00, 8'h18, 1'b1, 1'b1, 1'b0, 3'd4},
    '{24'h000B00, 6'd2,  8'h00, 8'h10, 1'b1, 1'b1, 1'b0, 3'd5},
    '{24'h000C00, 6'd0,  8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 3'd6},
    '{24'h000D10, 6'd17, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 3'd6},
    '{24'h000E00, 6'd33, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 3'd6}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [5:0]  len_i = '0;
  logic [31:0] timeout_i = 32'd100;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        byte_ready_o, busy_o, done_o;
  logic [2:0]  code_o;
  logic [22:0] fl_addr_o;
  logic [15:0] fl_dq_o;
  logic [15:0] fl_dq_i = '0;
  logic        fl_we_o, fl_re_o;

  flash_bufprog u0 (
    .clk_i(clk), .rst_ni, .start_i, .addr_i, .len_i, .timeout_i,
    .byte_valid_i, .byte_i, .byte_ready_o, .busy_o, .done_o, .code_o,
    .fl_addr_o, .fl_dq_o, .fl_dq_i, .fl_we_o, .fl_re_o
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // flash model and stream source state
  int         phase = 0, preads = 0, rem_words = 0, last_rd = -1, cad_err = 0;
  logic [7:0] pre_sr = '0, fin_sr = '0;
  bit         setup_ok = 1, conf_ok = 1, gap_on = 0, feed_on = 0, pend = 0;
  int         bidx = 0;
  logic [7:0] byts [64];
  int         n_log = 0, n_exp = 0;
  int         log_a [64], exp_a [64];
  logic [15:0] log_d [64], exp_d [64];
  bit         smode_b = 0;

  always @(negedge clk) begin
    if (fl_we_o) begin
      if (n_log < 64) begin log_a[n_log] = int'(fl_addr_o); log_d[n_log] = fl_dq_o; end
      n_log++;
      case (phase)
        0: if (fl_dq_o == 16'h00E8) phase = 1;
           else if (fl_dq_o == 16'h0050) pre_sr = pre_sr & ~8'h3A;
        1: if (fl_dq_o == 16'h0070) phase = 0;
        3: begin rem_words = int'(fl_dq_o) + 1; phase = 4; end
        4: begin rem_words--; if (rem_words == 0) phase = 5; end
        5: if (fl_dq_o == 16'h00D0) begin phase = 2; preads = 0; last_rd = -1; end
        2: if (fl_dq_o == 16'h0070) phase = 0;
        default: ;
      endcase
    end
    if (fl_re_o) begin
      case (phase)
        0: fl_dq_i = {8'h00, 1'b1, pre_sr[6:0]};
        1: begin
          fl_dq_i = setup_ok ? 16'h0080 : 16'h0000;
          if (setup_ok) phase = 3;
        end
        2: begin
          if (last_rd >= 0 && (int'(cyc) - last_rd) != 4) cad_err++;
          last_rd = int'(cyc);
          preads++;
          if (conf_ok && preads >= 3) begin
            fl_dq_i = {8'h00, fin_sr | 8'h80};
            pre_sr  = fin_sr;
            phase   = 0;
          end else fl_dq_i = 16'h0000;
        end
        default: fl_dq_i = 16'h0000;
      endcase
    end
    if (pend) bidx++;
    byte_valid_i = feed_on && !(gap_on && (cyc % 3 == 0));
    byte_i       = byts[bidx[5:0]];
    pend         = byte_ready_o && byte_valid_i;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, expv, expv);
    end
  endtask

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd0: return "R8";
      3'd1: return "R5";
      3'd2: return "R9";
      3'd6: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic push(input int a, input int d);
    exp_a[n_exp] = a; exp_d[n_exp] = 16'(d); n_exp++;
  endtask

  task automatic build_exp(input vec_t v);
    int cmdw, lane, words;
    logic [15:0] wd;
    n_exp = 0;
    if (v.len == 0 || (int'(v.a) % 32) + int'(v.len) > 32) return;
    cmdw = int'(v.a & ~24'h1F) >> 1;
    if (!smode_b) push(cmdw, 'h70);
    if ((v.pre & 8'h30) != 0) begin push(cmdw, 'h50); push(cmdw, 'h70); end
    push(cmdw, 'hE8);
    if (!v.sok) begin push(cmdw, 'h70); push(cmdw, 'h50); push(cmdw, 'h70); return; end
    lane  = int'(v.a[0]);
    words = (lane + int'(v.len) + 1) / 2;
    push(cmdw, words - 1);
    for (int w = 0; w < words; w++) begin
      wd = 16'hFFFF;
      for (int l = 0; l < 2; l++) begin
        int pos = w * 2 + l - lane;
        if (pos >= 0 && pos < int'(v.len)) wd[l*8 +: 8] = byts[pos];
      end
      push((int'(v.a) >> 1) + w, int'(wd));
    end
    push(cmdw, 'hD0);
    if (!v.cok) push(cmdw, 'h70);
    else if ((v.fin & 8'h1A) != 0) begin push(cmdw, 'h50); push(cmdw, 'h70); end
  endtask

  task automatic run_vec(input vec_t v, input int seed, input bit poke_busy);
    int k, ndone, extra, mism;
    logic [2:0] got;
    bit rej;
    for (int i = 0; i < 64; i++) byts[i] = 8'(i * 37 + seed * 11 + 5);
    pre_sr = v.pre; fin_sr = v.fin; setup_ok = v.sok; conf_ok = v.cok;
    gap_on = v.gap; phase = 0; n_log = 0; bidx = 0; pend = 0; feed_on = 1;
    rej = (v.len == 0 || (int'(v.a) % 32) + int'(v.len) > 32);
    build_exp(v);
    addr_i = v.a; len_i = v.len; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ndone = 0; got = '0; k = 0;
    while (ndone == 0 && k < 3000) begin
      if (done_o) begin ndone = 1; got = code_o; end
      else begin
        if (k == 1 && !rej) chk(busy_o, "R13", "busy during request", int'(busy_o), 1);
        if (poke_busy && k == 6) begin start_i = 1'b1; len_i = '0; end
        if (poke_busy && k == 7) start_i = 1'b0;
        @(negedge clk);
        k++;
      end
    end
    chk(ndone == 1, "R13", "done seen (watchdog)", ndone, 1);
    chk(got == v.code, req_of(v.code), "result code", int'(got), int'(v.code));
    extra = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (done_o) extra++; end
    chk(extra == 0, "R13", "done width / ignored start", extra, 0);
    chk(n_log == n_exp, "R1/R2/R3/R5/R6", "bus write count", n_log, n_exp);
    mism = -1;
    for (int i = 0; i < n_exp && i < n_log; i++)
      if (mism < 0 && (log_a[i] != exp_a[i] || log_d[i] != exp_d[i])) mism = i;
    if (mism >= 0)
      chk(0, "R4/R6/R7/R8", $sformatf("write %0d addr 0x%0h", mism, log_a[mism]),
          int'(log_d[mism]), int'(exp_d[mism]));
    else chk(1, "R7", "write sequence", 0, 0);
    if (!rej && v.sok)
      chk(bidx == int'(v.len), "R7", "bytes consumed", bidx, int'(v.len));
    if (!rej) smode_b = 1;
    feed_on = 0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !fl_we_o && !fl_re_o && !byte_ready_o, "R13",
        "idle outputs in reset", int'({busy_o, done_o, fl_we_o, fl_re_o, byte_ready_o}), 0);
    rst_ni = 1'b1;
    smode_b = 0;
    @(negedge clk);
    chk(!busy_o && !done_o && !fl_we_o && !fl_re_o, "R12", "idle after reset",
        int'({busy_o, done_o, fl_we_o, fl_re_o}), 0);
  endtask

  initial begin
    do_reset();
    for (int vi = 0; vi < NV; vi++) run_vec(VECS[vi], vi, 1'b0);
    // start while busy must be ignored
    run_vec(VECS[1], 20, 1'b1);
    // after a fresh reset, status mode is unknown again: leading 0x70 expected
    do_reset();
    run_vec(VECS[3], 21, 1'b0);
    run_vec(VECS[0], 22, 1'b0);
    chk(cad_err == 0, "R12", "poll read spacing errors", cad_err, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule